// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and decides, cycle by cycle, which port may keep writing when both ports select the same word. Each port brings an enable, a word address and a write strobe. When both enables are active and the addresses are equal, the port that settled later receives an active-low busy flag, and its write strobe toward the array is suppressed. The decision looks only at enables and addresses, so a pure read collision produces the same flag as a write collision. Once a winner is chosen, it keeps ownership until the collision ends. Only then is a fresh decision possible.

A strap input selects master or slave operation. As master, the block drives its busy outputs from its own decision and ignores the busy inputs. As slave, the busy outputs stay high and each port's busy input, driven by an external master, acts only as a write inhibit for that port. In this way several slices can share one master decision when a word is split across devices.

The decision is held in a three-state machine: IDLE (no collision), LEFT_OWNS (left port owns the word, right is busy) and RIGHT_OWNS (right port owns, left is busy). The transitions are IDLE to LEFT_OWNS on a collision the left port wins, IDLE to RIGHT_OWNS on a collision the right port wins, and either owning state back to IDLE when the collision ends or slave mode is selected. Each owning state stays put while the collision holds. The gated write strobes are combinational from the inputs and the registered state.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both busy outputs are high, and no gated write strobe is active unless its port writes.
- R2: A busy output goes low only after a clock edge at which both enables were 1 and both addresses were equal. Different addresses, or one enable at 0, leave both busy outputs high and both writes passing.
- R3: The write strobes take no part in the decision: a collision where both ports only read gives the same busy outcome as one with writes.
- R4: A port counts as moved at an edge when its enable is 1 and either its enable was 0 or its address differed at the previous edge. When a collision first appears and exactly one port moved, that port receives busy and the other wins.
- R5: When both ports move into a collision at the same edge, the left port wins (right busy low) with TIE_MODE = 0. Both busy outputs are never low together.
- R6: With TIE_MODE = 1, simultaneous arrivals alternate winners, starting with left after reset: left, right, left.
- R7: While the collision persists in master mode, the owner does not change, whatever the write strobes do.
- R8: The first clock edge that samples no collision, either because an address changed or an enable went to 0, returns both busy outputs high.
- R9: In master mode, a port whose busy output is low has its gated write strobe held at 0, whatever level sits on its busy input. The owner's writes pass.
- R10: With master_sel = 0, both busy outputs stay high, and a 0 on a port's busy input blocks only that port's gated write.
- R11: Busy changes only at a clock edge: the cycle in which a collision is first presented still shows both busy outputs high, and the cycle in which it ends still shows the old owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = master (drives busy), 0 = slave (busy inputs inhibit) |
| l_en | input | 1 | Left port enable |
| l_addr | input | AW | Left port word address |
| l_we | input | 1 | Left port write strobe |
| r_en | input | 1 | Right port enable |
| r_addr | input | AW | Right port word address |
| r_we | input | 1 | Right port write strobe |
| l_busy_n_in | input | 1 | Left busy from external master (slave mode), active low |
| r_busy_n_in | input | 1 | Right busy from external master (slave mode), active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr | output | 1 | Left write strobe after inhibit |
| r_wr | output | 1 | Right write strobe after inhibit |

## Verification
The bench goes after the order of arrival. It presents collisions where the left port settled first, where the right port settled first, and where both arrived together. A design that judged by write strobes or ignored the settling order would flag the wrong port, and one with a broken tie rule would flag both ports or none. It also re-forms a collision by moving the previous winner's address. A design that remembered the old owner instead of deciding afresh would keep busy on the wrong side. The master-mode busy input is driven low while a port owns the word, and in slave mode each busy input is driven low in turn. A design that mixed the two modes would block the owner's write or let an inhibited slave write through.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int NPORTS  = 2;
    localparam int PORT_L  = 0;
    localparam int PORT_R  = 1;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } own_state_t;
endpackage

// File: rtl/dpa_settle_track.sv
module dpa_settle_track #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          moved
);
    logic          en_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // A port has moved when it is enabled now and was either idle or
    // pointing elsewhere at the previous edge.
    always_comb begin
        moved = en && (!en_q || (addr != addr_q));
    end
endmodule

// File: rtl/dpa_own_fsm.sv
module dpa_own_fsm
    import dpa_pkg::*;
#(
    parameter int TIE_MODE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_sel,
    input  logic collide,
    input  logic moved_l,
    input  logic moved_r,
    output logic lose_l,
    output logic lose_r
);
    localparam logic ALTERNATE = (TIE_MODE != 0);

    own_state_t state_q, state_d;
    logic       tie_ptr_q, tie_ptr_d;
    logic       tie_take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tie_ptr_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            tie_ptr_q <= tie_ptr_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        tie_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (master_sel && collide) begin
                    if (moved_l && !moved_r) begin
                        state_d = ST_RIGHT_OWNS;
                    end else if (moved_r && !moved_l) begin
                        state_d = ST_LEFT_OWNS;
                    end else begin
                        tie_take = 1'b1;
                        state_d  = (ALTERNATE && tie_ptr_q) ? ST_RIGHT_OWNS
                                                            : ST_LEFT_OWNS;
                    end
                end
            end
            ST_LEFT_OWNS: begin
                if (!master_sel || !collide) state_d = ST_IDLE;
            end
            ST_RIGHT_OWNS: begin
                if (!master_sel || !collide) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        tie_ptr_d = ALTERNATE ? (tie_ptr_q ^ tie_take) : 1'b0;
    end

    // Outputs from the registered state
    always_comb begin
        lose_l = master_sel && (state_q == ST_RIGHT_OWNS);
        lose_r = master_sel && (state_q == ST_LEFT_OWNS);
    end
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
    input  logic master_sel,
    input  logic en,
    input  logic we,
    input  logic lose,
    input  logic busy_n_in,
    output logic busy_n,
    output logic wr
);
    logic inhibit;

    always_comb begin
        inhibit = master_sel ? lose : !busy_n_in;
        busy_n  = !lose;
        wr      = en && we && !inhibit;
    end
endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
    import dpa_pkg::*;
#(
    parameter int AW       = 14,
    parameter int TIE_MODE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_sel,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          l_we,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    input  logic          r_we,
    input  logic          l_busy_n_in,
    input  logic          r_busy_n_in,
    output logic          l_busy_n,
    output logic          r_busy_n,
    output logic          l_wr,
    output logic          r_wr
);
    logic [NPORTS-1:0] en_v, we_v, bin_v, lose_v, moved_v, busy_v, wr_v;
    logic [AW-1:0]     addr_v [NPORTS];
    logic              collide;

    always_comb begin
        en_v[PORT_L]   = l_en;
        en_v[PORT_R]   = r_en;
        we_v[PORT_L]   = l_we;
        we_v[PORT_R]   = r_we;
        bin_v[PORT_L]  = l_busy_n_in;
        bin_v[PORT_R]  = r_busy_n_in;
        addr_v[PORT_L] = l_addr;
        addr_v[PORT_R] = r_addr;
        collide        = l_en && r_en && (l_addr == r_addr);
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpa_settle_track #(.AW(AW)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .moved (moved_v[p])
        );

        dpa_write_gate u_gate (
            .master_sel (master_sel),
            .en         (en_v[p]),
            .we         (we_v[p]),
            .lose       (lose_v[p]),
            .busy_n_in  (bin_v[p]),
            .busy_n     (busy_v[p]),
            .wr         (wr_v[p])
        );
    end

    dpa_own_fsm #(.TIE_MODE(TIE_MODE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_sel (master_sel),
        .collide    (collide),
        .moved_l    (moved_v[PORT_L]),
        .moved_r    (moved_v[PORT_R]),
        .lose_l     (lose_v[PORT_L]),
        .lose_r     (lose_v[PORT_R])
    );

    assign l_busy_n = busy_v[PORT_L];
    assign r_busy_n = busy_v[PORT_R];
    assign l_wr     = wr_v[PORT_L];
    assign r_wr     = wr_v[PORT_R];
endmodule

// File: rtl/dpa_collision_arbiter_chk.sv
module dpa_collision_arbiter_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_sel,
    input logic          l_en,
    input logic [AW-1:0] l_addr,
    input logic          r_en,
    input logic [AW-1:0] r_addr,
    input logic          l_busy_n_in,
    input logic          r_busy_n_in,
    input logic          l_busy_n,
    input logic          r_busy_n,
    input logic          l_wr,
    input logic          r_wr
);
    logic same_word;
    assign same_word = l_en && r_en && (l_addr == r_addr);

    p_busy_cause_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> $past(same_word));
    p_busy_cause_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> $past(same_word));
    p_one_loser_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));
    p_hold_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && same_word && master_sel) |=> (!l_busy_n || !master_sel));
    p_hold_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && same_word && master_sel) |=> (!r_busy_n || !master_sel));
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !same_word |=> (l_busy_n && r_busy_n));
    p_block_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !l_busy_n) |-> !l_wr);
    p_block_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !r_busy_n) |-> !r_wr);
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (l_busy_n && r_busy_n));
    p_slave_inh_l_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !l_busy_n_in) |-> !l_wr);
    p_slave_inh_r_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !r_busy_n_in) |-> !r_wr);
endmodule

bind dpa_collision_arbiter dpa_collision_arbiter_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_sel  (master_sel),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .l_busy_n_in (l_busy_n_in),
    .r_busy_n_in (r_busy_n_in),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr        (l_wr),
    .r_wr        (r_wr)
);

// File: tb/test_dpa_collision_arbiter.sv
`timescale 1ns/1ps
module test_dpa_collision_arbiter;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          master_sel;
    logic          l_en, r_en, l_we, r_we;
    logic [AW-1:0] l_addr, r_addr;
    logic          l_busy_n_in, r_busy_n_in;
    logic          l_busy_n, r_busy_n, l_wr, r_wr;
    logic          a_busy_l, a_busy_r, a_wr_l, a_wr_r;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    dpa_collision_arbiter #(.AW(AW), .TIE_MODE(0)) i_dpa_collision_arbiter (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .l_en(l_en), .l_addr(l_addr), .l_we(l_we),
        .r_en(r_en), .r_addr(r_addr), .r_we(r_we),
        .l_busy_n_in(l_busy_n_in), .r_busy_n_in(r_busy_n_in),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr(l_wr), .r_wr(r_wr)
    );

    dpa_collision_arbiter #(.AW(AW), .TIE_MODE(1)) i_dpa_collision_arbiter_alt (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .l_en(l_en), .l_addr(l_addr), .l_we(l_we),
        .r_en(r_en), .r_addr(r_addr), .r_we(r_we),
        .l_busy_n_in(l_busy_n_in), .r_busy_n_in(r_busy_n_in),
        .l_busy_n(a_busy_l), .r_busy_n(a_busy_r), .l_wr(a_wr_l), .r_wr(a_wr_r)
    );

    // Observed vector: {l_busy_n, r_busy_n, l_wr, r_wr}
    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (busy_l busy_r wr_l wr_r)", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        l_en = 0; r_en = 0; l_we = 0; r_we = 0;
        l_addr = '0; r_addr = '0;
        l_busy_n_in = 1; r_busy_n_in = 1;
        master_sel = 1;
    endtask

    task automatic settle_idle();
        idle_inputs();
        step(); step();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        step(); step();
        check("R1 during reset", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1100);
        rst_n = 1;
        step();
    endtask

    task automatic t_reset();
        check("R1 after reset", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1100);
        check("R1 after reset alt", {a_busy_l, a_busy_r, a_wr_l, a_wr_r}, 4'b1100);
    endtask

    task automatic t_no_match();
        l_en = 1; r_en = 1; l_addr = 14'h0010; r_addr = 14'h0020; l_we = 1; r_we = 1;
        step();
        check("R2 different addresses", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1111);
        r_en = 0; r_addr = 14'h0010;
        step();
        check("R2 one enable off", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1110);
        settle_idle();
    endtask

    task automatic t_left_first();
        l_en = 1; l_addr = 14'h0155;
        step();
        r_en = 1; r_addr = 14'h0155;
        step();
        check("R4 R3 left settled first, reads only", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1000);
        l_we = 1; r_we = 1;
        #1;
        check("R9 loser write blocked", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1010);
        l_busy_n_in = 0; r_busy_n_in = 1;
        #1;
        check("R9 busy input ignored in master", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1010);
        settle_idle();
    endtask

    task automatic t_right_first();
        r_en = 1; r_addr = 14'h2AAA;
        step();
        l_en = 1; l_addr = 14'h2AAA; l_we = 1; r_we = 1;
        step();
        check("R4 right settled first", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b0101);
        settle_idle();
    endtask

    task automatic t_tie();
        l_en = 1; r_en = 1; l_addr = 14'h3FFF; r_addr = 14'h3FFF;
        #1;
        check("R11 no busy before edge", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1100);
        step();
        check("R5 tie goes left", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1000);
        settle_idle();
    endtask

    task automatic t_hold_release();
        l_en = 1; l_addr = 14'h0042;
        step();
        r_en = 1; r_addr = 14'h0042;
        step();
        for (int i = 0; i < 3; i++) begin
            l_we = i[0]; r_we = ~i[0];
            step();
            check("R7 owner kept", {l_busy_n, r_busy_n}, 2'b10);
        end
        l_we = 0; r_we = 0;
        l_addr = 14'h0043;
        #1;
        check("R11 release waits for edge", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1000);
        step();
        check("R8 released on address change", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1100);
        l_addr = 14'h0042;
        step();
        check("R4 fresh decision, left moved", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b0100);
        r_en = 0;
        step();
        check("R8 released on enable drop", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1100);
        settle_idle();
    endtask

    task automatic t_alternate();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            l_en = 1; r_en = 1; l_addr = 14'h1234; r_addr = 14'h1234;
            step();
            check("R6 alternating tie", {a_busy_l, a_busy_r}, (k == 1) ? 2'b01 : 2'b10);
            check("R5 fixed tie unchanged", {l_busy_n, r_busy_n}, 2'b10);
            settle_idle();
        end
    endtask

    task automatic t_slave();
        master_sel = 0;
        l_en = 1; r_en = 1; l_addr = 14'h0777; r_addr = 14'h0777; l_we = 1; r_we = 1;
        step();
        check("R10 slave busy outputs high", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1111);
        l_busy_n_in = 0;
        #1;
        check("R10 left inhibited only", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1101);
        l_busy_n_in = 1; r_busy_n_in = 0;
        #1;
        check("R10 right inhibited only", {l_busy_n, r_busy_n, l_wr, r_wr}, 4'b1110);
        settle_idle();
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        step();
        do_reset();
        t_reset();
        t_no_match();
        t_left_first();
        t_right_first();
        t_tie();
        t_hold_release();
        t_alternate();
        t_slave();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule